// File: doc/BRIEF.md
# Matrix Keypad Scanner with Key Lockout

This block scans a sixteen-key matrix keypad arranged as four rows by four columns. It pulls one column line low at a time, reads the four row lines, filters contact bounce, and turns the position of a pressed key into a hexadecimal code. The block keeps the two most recent codes as a pair of digits and raises a single-cycle strobe each time a new code enters that pair.

Once a key is accepted, the scanner stops on that key's column and reads nothing else until every row of that column has read idle for a full filter interval. It then resumes stepping through the columns. The row lines are asynchronous and are synchronised inside the block. The column step rate and the filter length are parameters. At the defaults, the block makes one column step per millisecond from a 48 MHz clock and needs twenty stable steps, about 20 ms.

Top module: `keypad_scanner`

## Requirements
- R1: After reset both history digits are 0, the strobe is low, and column 0 is driven (cols_n = 4'b1110).
- R2: While no key is held, exactly one column output is low. The low column advances in the order 0, 1, 2, 3, 0 once every STEP_DIV clocks.
- R3: A key that connects row r (rows_n bit r) to column c (cols_n bit c) is reported as code 4*r + c.
- R4: While an accepted key is held, the driven column does not change, and presses of keys in other columns produce no strobe and leave the digits unchanged.
- R5: A key is released once all rows of its column have read high for DEB_TICKS column steps. Scanning then resumes, so a different key that is still held is accepted afterwards.
- R6: A press is accepted only after its row reading has matched on DEB_TICKS column steps following its first detection. A shorter press produces no strobe.
- R7: If two or more rows read low in the driven column, the reading is ignored and no strobe occurs.
- R8: On each accepted key, the high digit takes the old low digit and the low digit takes the new code.
- R9: The strobe is high for exactly one clock, in the same cycle the digits take their new values. The digits hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rows_n | input | 4 | Row lines, idle high, low when a key in the driven column is closed |
| cols_n | output | 4 | Column drive, active low, one column at a time |
| digit_hi | output | 4 | Older of the two most recent key codes |
| digit_lo | output | 4 | Most recent key code |
| key_strobe | output | 1 | One-clock pulse when the digits update |

## Verification
A column step lands every STEP_DIV clocks, so the bench samples cols_n on falling edges exactly STEP_DIV clocks apart. Each such sample must show the next column, whatever the phase of the divider. A press can be accepted only after the scan reaches its column and the filter runs its DEB_TICKS steps, with two synchroniser stages and one output register on the path. The bench therefore waits for the strobe within a bound of (4 + DEB_TICKS + 2) steps plus margin, and it reads the digits on the same falling edge that shows the strobe. The negative checks watch for the whole of that bound and confirm that neither the strobe nor the digits move.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
    localparam int unsigned NUM_ROWS = 4;
    localparam int unsigned NUM_COLS = 4;
    localparam int unsigned ROW_W    = $clog2(NUM_ROWS);
    localparam int unsigned COL_W    = $clog2(NUM_COLS);
    localparam int unsigned CODE_W   = ROW_W + COL_W;

    typedef enum logic [1:0] {
        ST_SCAN    = 2'd0,
        ST_PRESS   = 2'd1,
        ST_HELD    = 2'd2,
        ST_RELEASE = 2'd3
    } scan_state_e;
endpackage

// File: rtl/kpd_sync.sv
module kpd_sync #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q, meta_d, sync_q, sync_d;
        always_comb begin
            meta_d = din[i];
            sync_d = meta_q;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= meta_d;
                sync_q <= sync_d;
            end
        end
        assign dout[i] = sync_q;
    end
endmodule

// File: rtl/kpd_tick.sv
module kpd_tick #(
    parameter int unsigned DIV = 48000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_t;

    tick_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.tick = 1'b0;
        if (r_q.cnt == LAST) begin
            r_d.cnt  = '0;
            r_d.tick = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick = r_q.tick;
endmodule

// File: rtl/kpd_fsm.sv
module kpd_fsm
    import kpd_pkg::*;
#(
    parameter int unsigned DEB_TICKS = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [NUM_ROWS-1:0] rows_s,
    output logic [NUM_COLS-1:0] cols_n,
    output logic                accept,
    output logic [CODE_W-1:0]   code
);
    localparam int unsigned DW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
    localparam logic [DW-1:0] DEB_LAST = DW'(DEB_TICKS - 1);
    localparam logic [NUM_ROWS-1:0] IDLE = '1;

    typedef struct packed {
        scan_state_e         state;
        logic [COL_W-1:0]    col;
        logic [ROW_W-1:0]    row;
        logic [NUM_ROWS-1:0] pat;
        logic [DW-1:0]       cnt;
        logic                accept;
        logic [CODE_W-1:0]   code;
    } fsm_t;

    fsm_t s_d, s_q;
    logic             single_low;
    logic [ROW_W-1:0] low_idx;

    // locate the single active row, if exactly one is active
    always_comb begin
        low_idx = '0;
        for (int r = NUM_ROWS - 1; r >= 0; r--) begin
            if (!rows_s[r]) low_idx = ROW_W'(r);
        end
        single_low = ($countones(~rows_s) == 1);
    end

    always_comb begin
        s_d        = s_q;
        s_d.accept = 1'b0;
        if (tick) begin
            unique case (s_q.state)
                ST_SCAN: begin
                    if (single_low) begin
                        s_d.state = ST_PRESS;
                        s_d.pat   = rows_s;
                        s_d.row   = low_idx;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.col = s_q.col + 1'b1;
                    end
                end
                ST_PRESS: begin
                    if (rows_s == s_q.pat) begin
                        if (s_q.cnt == DEB_LAST) begin
                            s_d.state  = ST_HELD;
                            s_d.accept = 1'b1;
                            s_d.code   = {s_q.row, s_q.col};
                        end else begin
                            s_d.cnt = s_q.cnt + 1'b1;
                        end
                    end else begin
                        s_d.state = ST_SCAN;
                        s_d.col   = s_q.col + 1'b1;
                    end
                end
                ST_HELD: begin
                    if (rows_s == IDLE) begin
                        s_d.state = ST_RELEASE;
                        s_d.cnt   = '0;
                    end
                end
                ST_RELEASE: begin
                    if (rows_s != IDLE) begin
                        s_d.state = ST_HELD;
                    end else if (s_q.cnt == DEB_LAST) begin
                        s_d.state = ST_SCAN;
                        s_d.col   = s_q.col + 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.state = ST_SCAN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_SCAN;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        cols_n = '1;
        cols_n[s_q.col] = 1'b0;
    end
    assign accept = s_q.accept;
    assign code   = s_q.code;

    p_one_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cols_n) == 1);
    p_col_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_HELD) |=> $stable(cols_n));
    p_single_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($countones(~$past(rows_s)) == 1));
endmodule

// File: rtl/kpd_history.sv
module kpd_history
    import kpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] digit_hi,
    output logic [CODE_W-1:0] digit_lo,
    output logic              strobe
);
    typedef struct packed {
        logic [CODE_W-1:0] hi;
        logic [CODE_W-1:0] lo;
        logic              strobe;
    } hist_t;

    hist_t h_d, h_q;

    always_comb begin
        h_d        = h_q;
        h_d.strobe = 1'b0;
        if (accept) begin
            h_d.hi     = h_q.lo;
            h_d.lo     = code;
            h_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign digit_hi = h_q.hi;
    assign digit_lo = h_q.lo;
    assign strobe   = h_q.strobe;

    p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (digit_hi == $past(digit_lo)));
    p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);
    p_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> ($stable(digit_hi) && $stable(digit_lo)));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kpd_pkg::*;
#(
    parameter int unsigned STEP_DIV  = 48000,
    parameter int unsigned DEB_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rows_n,
    output logic [3:0] cols_n,
    output logic [3:0] digit_hi,
    output logic [3:0] digit_lo,
    output logic       key_strobe
);
    logic                tick;
    logic [NUM_ROWS-1:0] rows_s;
    logic                accept;
    logic [CODE_W-1:0]   code;

    kpd_sync #(.WIDTH(NUM_ROWS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rows_n),
        .dout (rows_s)
    );

    kpd_tick #(.DIV(STEP_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    kpd_fsm #(.DEB_TICKS(DEB_TICKS)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .rows_s(rows_s),
        .cols_n(cols_n),
        .accept(accept),
        .code  (code)
    );

    kpd_history u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .code    (code),
        .digit_hi(digit_hi),
        .digit_lo(digit_lo),
        .strobe  (key_strobe)
    );

    initial begin
        assert (STEP_DIV >= 4) else $error("STEP_DIV must cover the synchroniser delay");
        assert (DEB_TICKS >= 1) else $error("DEB_TICKS must be at least 1");
    end
endmodule

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
    localparam int STEP = 8;
    localparam int DEB  = 4;
    localparam int WIN  = (4 + DEB + 2) * STEP + 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rows_n;
    logic [3:0] cols_n, digit_hi, digit_lo;
    logic       key_strobe;
    logic [15:0] keys = '0;

    int total = 0, bad = 0;
    int strobes = 0;
    logic prev_strobe = 1'b0;
    logic [3:0] m_hi = 4'd0, m_lo = 4'd0;

    always #2 clk = ~clk;

    keypad_scanner #(.STEP_DIV(STEP), .DEB_TICKS(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .rows_n(rows_n), .cols_n(cols_n),
        .digit_hi(digit_hi), .digit_lo(digit_lo), .key_strobe(key_strobe)
    );

    // matrix model: row r pulled low when a closed key sits on a driven column
    always_comb begin
        for (int r = 0; r < 4; r++) begin
            rows_n[r] = 1'b1;
            for (int c = 0; c < 4; c++)
                if (keys[4*r+c] && !cols_n[c]) rows_n[r] = 1'b0;
        end
    end

    function automatic logic [3:0] code_of(int r, int c);
        return 4'(4*r + c);
    endfunction

    function automatic logic [3:0] next_col(logic [3:0] cn);
        return {cn[2:0], cn[3]};
    endfunction

    task automatic check(string req, logic ok, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (key_strobe) strobes++;
            if (key_strobe && prev_strobe) begin
                total++; bad++;
                $display("FAIL R9 actual=2 expected=1 (strobe width)");
            end
            prev_strobe <= key_strobe;
        end
    end

    task automatic expect_key(int r, int c, string req);
        int start = strobes;
        int waited = 0;
        while (strobes == start && waited < WIN) begin
            @(negedge clk); waited++;
        end
        check(req, strobes == start + 1, strobes - start, 1);
        m_hi = m_lo;
        m_lo = code_of(r, c);
        check("R8", digit_hi == m_hi, digit_hi, m_hi);
        check("R3", digit_lo == m_lo, digit_lo, m_lo);
    endtask

    task automatic expect_none(int cycles, string req);
        int start = strobes;
        repeat (cycles) @(negedge clk);
        check(req, strobes == start, strobes - start, 0);
        check(req, digit_hi == m_hi && digit_lo == m_lo,
              {digit_hi, digit_lo}, {m_hi, m_lo});
    endtask

    task automatic release_all();
        keys = '0;
        repeat (WIN) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [3:0] c0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", digit_hi == 0 && digit_lo == 0, {digit_hi, digit_lo}, 0);
        check("R1", key_strobe == 1'b0, key_strobe, 0);
        check("R1", cols_n == 4'b1110, cols_n, 4'b1110);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R2 column rotation at idle
        for (int i = 0; i < 4; i++) begin
            c0 = cols_n;
            repeat (STEP) @(negedge clk);
            check("R2", cols_n == next_col(c0), cols_n, next_col(c0));
        end
        // R3/R8 directed corners
        keys[code_of(0, 0)] = 1'b1; expect_key(0, 0, "R3"); release_all();
        keys[code_of(3, 3)] = 1'b1; expect_key(3, 3, "R3"); release_all();
        // R6 short press rejected
        keys[code_of(2, 1)] = 1'b1;
        repeat (2 * STEP) @(negedge clk);
        keys = '0;
        expect_none(WIN, "R6");
        // R7 two rows in one column ignored
        keys[code_of(0, 1)] = 1'b1; keys[code_of(2, 1)] = 1'b1;
        expect_none(WIN, "R7");
        release_all();
        // R4 lockout and R5 resume
        keys[code_of(1, 0)] = 1'b1;
        expect_key(1, 0, "R4");
        c0 = cols_n;
        keys[code_of(2, 3)] = 1'b1;
        expect_none(WIN, "R4");
        check("R4", cols_n == c0, cols_n, c0);
        repeat (STEP) @(negedge clk);
        check("R4", cols_n == c0, cols_n, c0);
        keys[code_of(1, 0)] = 1'b0;
        expect_key(2, 3, "R5");
        release_all();
        // random presses
        for (int i = 0; i < 24; i++) begin
            int r = int'($urandom_range(3, 0));
            int c = int'($urandom_range(3, 0));
            keys[code_of(r, c)] = 1'b1;
            expect_key(r, c, "R3");
            repeat (int'($urandom_range(30, 0))) @(negedge clk);
            release_all();
        end
        expect_none(WIN, "R9");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule